// File: doc/BRIEF.md
# Priority Vectored Interrupt Controller

This block gathers a parameterised number of peripheral interrupt requests and eight trap requests and reduces them to a single request toward a CPU. Each peripheral source has a pending flag and, as configuration inputs, an enable bit and a 3-bit priority. The block arbitrates among the pending candidates and presents the winner's vector number, its level and the word address of its table entry. It requests service only when that winner outranks the level the CPU is running at.

Vector numbering is global. Traps take vector numbers 0 to 7 and peripheral source n takes vector number 8+n. The table entry of vector v sits at `base + 2*v`. The base is either the primary base (0x000004) or an alternate base (0x000104), chosen at run time by a select input. An acknowledge strobe takes the current winner into service: it clears that winner's pending flag and saves the running level on a small stack. A return strobe restores the saved level.

Top module: `pic_vectored_ctrl`

## Requirements
- R1: After reset no flag is pending, `vec_valid_o` and `irq_o` are 0 and `cur_lvl_o` is 0.
- R2: A source whose priority field is 0, or whose enable bit is 0, is never chosen as the winner. Its pending flag may still be set.
- R3: Among eligible sources the highest priority wins. Priority 7 is the highest and 1 is the lowest. When priorities tie, the lower vector number wins. The winner is reported with `vec_lvl_o` equal to its priority.
- R4: Any pending trap beats every source. When several traps are pending, the lowest trap number wins. A trap winner is reported with `vec_lvl_o` = 8.
- R5: Vector number v (trap t is v=t, source n is v=8+n) is reported on `vec_num_o`. `vec_addr_o` = base + 2*v, and with `alt_sel_i`=0 the base is 0x000004, so trap 0 is at 0x000004, trap 7 at 0x000012 and source 0 at 0x000014.
- R6: With `alt_sel_i`=1 every address uses base 0x000104 instead. The switch acts in the same cycle, without a clock edge.
- R7: `irq_o` is 1 only when a winner exists and its level is strictly greater than `cur_lvl_o`.
- R8: An `ack_i` seen at a clock edge while `irq_o`=1 clears the winner's pending flag, pushes `cur_lvl_o` onto the stack and sets `cur_lvl_o` to the winner's level. An `ack_i` seen while `irq_o`=0 changes nothing.
- R9: `reti_i` pops the last saved level into `cur_lvl_o`. A `reti_i` with an empty stack is ignored. When a granted `ack_i` falls in the same cycle, `reti_i` is ignored.
- R10: A request sets the source's or trap's pending flag at the clock edge. The flag stays set after the request drops, until it is cleared by a granted acknowledge. A request present in the same cycle as its own clear leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| src_req_i | input | NUM_SRC | Peripheral request per source |
| src_en_i | input | NUM_SRC | Enable per source |
| src_prio_i | input | 3*NUM_SRC | Priority per source; source n at bits [3n+2:3n] |
| trap_req_i | input | 8 | Trap request per trap |
| alt_sel_i | input | 1 | 1 selects the alternate table base |
| ack_i | input | 1 | Acknowledge strobe from the CPU |
| reti_i | input | 1 | Return-from-interrupt strobe |
| irq_o | output | 1 | Preemption request to the CPU |
| vec_valid_o | output | 1 | A winner exists |
| vec_num_o | output | clog2(NUM_SRC+8) | Winning vector number |
| vec_lvl_o | output | 4 | Winner level (1..7, or 8 for traps) |
| vec_addr_o | output | ADDR_W | Table word address of the winner |
| cur_lvl_o | output | 4 | Level the CPU is running at |

## Verification
The hardest case to reach is a nested sequence: a trap arrives while a high-priority source is in service, a second pending request is held back because its level equals the running level, and returns then unwind the stack one level at a time until the held request fires again. A directed sequence builds exactly this nesting, including an acknowledge that coincides with a fresh request and an acknowledge that coincides with a return. A long random phase then mixes requests, priority rewrites, enable changes, table switches and strobes. A behavioural model checks every output against its own expectation on every cycle.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int PRIO_W = 3;
  localparam int LVL_W  = 4;
  localparam logic [LVL_W-1:0] TRAP_LVL = 4'd8;
endpackage

// File: rtl/pic_pend_bank.sv
module pic_pend_bank
  import pic_pkg::*;
#(
  parameter int NUM_SRC  = 32,
  parameter int NUM_TRAP = 8,
  parameter int VEC_W    = 6
) (
  input  logic                clk_i,
  input  logic                rst_n_i,
  input  logic [NUM_SRC-1:0]  src_req_i,
  input  logic [NUM_TRAP-1:0] trap_req_i,
  input  logic                clr_en_i,
  input  logic [VEC_W-1:0]    clr_vec_i,
  output logic [NUM_SRC-1:0]  src_pend_o,
  output logic [NUM_TRAP-1:0] trap_pend_o
);

  logic [NUM_SRC-1:0]  src_q, src_d, src_upd, src_hit;
  logic [NUM_TRAP-1:0] trap_q, trap_d, trap_upd, trap_hit;

  for (genvar t = 0; t < NUM_TRAP; t++) begin : g_trap
    always_comb begin
      trap_hit[t] = clr_en_i && (clr_vec_i == VEC_W'(t));
      trap_upd[t] = trap_req_i[t] | trap_hit[t];
      trap_d[t]   = trap_req_i[t] | (trap_q[t] & ~trap_hit[t]);
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i)         trap_q[t] <= 1'b0;
      else if (trap_upd[t]) trap_q[t] <= trap_d[t];
    end
  end

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    always_comb begin
      src_hit[s] = clr_en_i && (clr_vec_i == VEC_W'(NUM_TRAP + s));
      src_upd[s] = src_req_i[s] | src_hit[s];
      src_d[s]   = src_req_i[s] | (src_q[s] & ~src_hit[s]);
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i)        src_q[s] <= 1'b0;
      else if (src_upd[s]) src_q[s] <= src_d[s];
    end

    // R10
    pend_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (src_q[s] && !src_hit[s]) |=> src_q[s]);
    // R8
    pend_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (src_hit[s] && !src_req_i[s]) |=> !src_q[s]);
  end

  assign src_pend_o  = src_q;
  assign trap_pend_o = trap_q;

endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter
  import pic_pkg::*;
#(
  parameter int NUM_SRC  = 32,
  parameter int NUM_TRAP = 8,
  parameter int VEC_W    = 6
) (
  input  logic [NUM_SRC-1:0]        src_pend_i,
  input  logic [NUM_SRC-1:0]        src_en_i,
  input  logic [NUM_SRC*PRIO_W-1:0] src_prio_i,
  input  logic [NUM_TRAP-1:0]       trap_pend_i,
  output logic                      win_valid_o,
  output logic [VEC_W-1:0]          win_vec_o,
  output logic [LVL_W-1:0]          win_lvl_o
);

  logic [PRIO_W-1:0] prio_arr [NUM_SRC];
  logic [NUM_SRC-1:0] elig;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_elig
    assign prio_arr[s] = src_prio_i[s*PRIO_W +: PRIO_W];
    assign elig[s]     = src_pend_i[s] & src_en_i[s] & (|prio_arr[s]);
  end

  // Descending scans with >= leave the lowest index on ties; traps scanned last override.
  always_comb begin
    win_valid_o = 1'b0;
    win_vec_o   = '0;
    win_lvl_o   = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (elig[i] && ({1'b0, prio_arr[i]} >= win_lvl_o)) begin
        win_valid_o = 1'b1;
        win_vec_o   = VEC_W'(NUM_TRAP + i);
        win_lvl_o   = {1'b0, prio_arr[i]};
      end
    end
    for (int t = NUM_TRAP - 1; t >= 0; t--) begin
      if (trap_pend_i[t]) begin
        win_valid_o = 1'b1;
        win_vec_o   = VEC_W'(t);
        win_lvl_o   = TRAP_LVL;
      end
    end
  end

endmodule

// File: rtl/pic_level_stack.sv
module pic_level_stack
  import pic_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic             push_i,
  input  logic [LVL_W-1:0] push_lvl_i,
  input  logic             pop_i,
  output logic [LVL_W-1:0] cur_lvl_o
);

  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int IDX_W = $clog2(DEPTH);

  logic [LVL_W-1:0] cur_q, cur_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_m1;
  logic [LVL_W-1:0] stk_q [DEPTH];
  logic [LVL_W-1:0] stk_d [DEPTH];
  logic             room, upd;

  assign cnt_m1 = cnt_q - 1'b1;
  assign room   = (cnt_q < CNT_W'(DEPTH));
  assign upd    = push_i | pop_i;

  always_comb begin
    cur_d = cur_q;
    cnt_d = cnt_q;
    stk_d = stk_q;
    if (push_i) begin
      cur_d = push_lvl_i;
      if (room) begin
        stk_d[cnt_q[IDX_W-1:0]] = cur_q;
        cnt_d = cnt_q + 1'b1;
      end
    end else if (pop_i && (cnt_q != '0)) begin
      cur_d = stk_q[cnt_m1[IDX_W-1:0]];
      cnt_d = cnt_m1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      cur_q <= '0;
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) stk_q[i] <= '0;
    end else if (upd) begin
      cur_q <= cur_d;
      cnt_q <= cnt_d;
      stk_q <= stk_d;
    end
  end

  assign cur_lvl_o = cur_q;

  // R8
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    push_i |-> room);
  // R8
  push_level_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    push_i |=> (cur_q == $past(push_lvl_i)));
  // R9
  empty_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (pop_i && !push_i && (cnt_q == '0)) |=> $stable(cur_q));

endmodule

// File: rtl/pic_vectored_ctrl.sv
module pic_vectored_ctrl
  import pic_pkg::*;
#(
  parameter int          NUM_SRC     = 32,
  parameter int          NUM_TRAP    = 8,
  parameter int          ADDR_W      = 24,
  parameter int          STACK_DEPTH = 8,
  parameter logic [23:0] PRI_BASE    = 24'h000004,
  parameter logic [23:0] ALT_BASE    = 24'h000104,
  localparam int         VEC_W       = $clog2(NUM_SRC + NUM_TRAP)
) (
  input  logic                      clk_i,
  input  logic                      rst_n_i,
  input  logic [NUM_SRC-1:0]        src_req_i,
  input  logic [NUM_SRC-1:0]        src_en_i,
  input  logic [NUM_SRC*PRIO_W-1:0] src_prio_i,
  input  logic [NUM_TRAP-1:0]       trap_req_i,
  input  logic                      alt_sel_i,
  input  logic                      ack_i,
  input  logic                      reti_i,
  output logic                      irq_o,
  output logic                      vec_valid_o,
  output logic [VEC_W-1:0]          vec_num_o,
  output logic [LVL_W-1:0]          vec_lvl_o,
  output logic [ADDR_W-1:0]         vec_addr_o,
  output logic [LVL_W-1:0]          cur_lvl_o
);

  logic [NUM_SRC-1:0]  src_pend;
  logic [NUM_TRAP-1:0] trap_pend;
  logic                win_valid, grant, pop;
  logic [VEC_W-1:0]    win_vec;
  logic [LVL_W-1:0]    win_lvl, cur_lvl;
  logic [ADDR_W-1:0]   base;

  pic_pend_bank #(.NUM_SRC(NUM_SRC), .NUM_TRAP(NUM_TRAP), .VEC_W(VEC_W)) pend_i (
    .clk_i(clk_i), .rst_n_i(rst_n_i),
    .src_req_i(src_req_i), .trap_req_i(trap_req_i),
    .clr_en_i(grant), .clr_vec_i(win_vec),
    .src_pend_o(src_pend), .trap_pend_o(trap_pend)
  );

  pic_arbiter #(.NUM_SRC(NUM_SRC), .NUM_TRAP(NUM_TRAP), .VEC_W(VEC_W)) arb_i (
    .src_pend_i(src_pend), .src_en_i(src_en_i), .src_prio_i(src_prio_i),
    .trap_pend_i(trap_pend),
    .win_valid_o(win_valid), .win_vec_o(win_vec), .win_lvl_o(win_lvl)
  );

  pic_level_stack #(.DEPTH(STACK_DEPTH)) stk_i (
    .clk_i(clk_i), .rst_n_i(rst_n_i),
    .push_i(grant), .push_lvl_i(win_lvl), .pop_i(pop),
    .cur_lvl_o(cur_lvl)
  );

  assign irq_o       = win_valid && (win_lvl > cur_lvl);
  assign grant       = ack_i & irq_o;
  assign pop         = reti_i & ~grant;
  assign base        = alt_sel_i ? ADDR_W'(ALT_BASE) : ADDR_W'(PRI_BASE);
  assign vec_valid_o = win_valid;
  assign vec_num_o   = win_vec;
  assign vec_lvl_o   = win_lvl;
  assign vec_addr_o  = base + (ADDR_W'(win_vec) << 1);
  assign cur_lvl_o   = cur_lvl;

  // R2
  no_zero_lvl_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    vec_valid_o |-> (vec_lvl_o != '0));
  // R4
  trap_first_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (|trap_pend) |-> ((vec_lvl_o == TRAP_LVL) && (vec_num_o < VEC_W'(NUM_TRAP))));
  // R7
  irq_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    irq_o |-> vec_valid_o);
  // R8
  ack_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (ack_i && !irq_o && !reti_i) |=> $stable(cur_lvl_o));

endmodule

// File: tb/pic_vectored_ctrl_tb_top.sv
module pic_vectored_ctrl_tb_top;
  localparam int NS = 32;
  localparam int NT = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NS-1:0]   src_req = '0, src_en = '0;
  logic [NS*3-1:0] src_prio = '0;
  logic [NT-1:0]   trap_req = '0;
  logic alt_sel = 1'b0, ack = 1'b0, reti = 1'b0;
  logic irq, vvalid;
  logic [5:0]  vnum;
  logic [3:0]  vlvl, cur;
  logic [23:0] vaddr;

  int errors = 0, checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pic_vectored_ctrl dut_i (
    .clk_i(clk), .rst_n_i(rst_n), .src_req_i(src_req), .src_en_i(src_en),
    .src_prio_i(src_prio), .trap_req_i(trap_req), .alt_sel_i(alt_sel),
    .ack_i(ack), .reti_i(reti), .irq_o(irq), .vec_valid_o(vvalid),
    .vec_num_o(vnum), .vec_lvl_o(vlvl), .vec_addr_o(vaddr), .cur_lvl_o(cur)
  );

  // behavioural reference model
  bit mpend [NS];
  bit mtrap [NT];
  int mcur = 0;
  int mstk [$];

  function automatic void mwin(output bit v, output int vec, output int lvl);
    v = 0; vec = 0; lvl = 0;
    for (int t = 0; t < NT; t++)
      if (mtrap[t] && !v) begin v = 1; vec = t; lvl = 8; end
    if (v) return;
    for (int n = 0; n < NS; n++) begin
      int p = int'(src_prio[3*n +: 3]);
      if (mpend[n] && src_en[n] && p != 0 && p > lvl) begin v = 1; vec = n + 8; lvl = p; end
    end
  endfunction

  always @(posedge clk) begin
    if (rst_n) begin
      bit v; int vec, lvl, g;
      mwin(v, vec, lvl);
      g = (ack && v && lvl > mcur);
      if (g) begin
        if (vec < NT) mtrap[vec] = 0; else mpend[vec-8] = 0;
        mstk.push_back(mcur); mcur = lvl;
      end else if (reti && mstk.size() > 0) mcur = mstk.pop_back();
      for (int n = 0; n < NS; n++) if (src_req[n]) mpend[n] = 1;
      for (int t = 0; t < NT; t++) if (trap_req[t]) mtrap[t] = 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit v; int vec, lvl, eaddr;
      mwin(v, vec, lvl);
      eaddr = (alt_sel ? 'h104 : 'h4) + 2*vec;
      chk(vvalid == v, "R3 valid", vvalid, v);
      if (v) begin
        chk(int'(vnum) == vec, "R3/R4 vector", vnum, vec);
        chk(int'(vlvl) == lvl, "R3/R4 level", vlvl, lvl);
        chk(int'(vaddr) == eaddr, "R5/R6 address", vaddr, eaddr);
      end
      chk(irq == (v && lvl > mcur), "R7 irq", irq, (v && lvl > mcur));
      chk(int'(cur) == mcur, "R8/R9 cur level", cur, mcur);
    end
  end

  task automatic cyc(); @(posedge clk); #2; endtask

  task automatic expect_out(input bit ev, input int evec, input int eaddr,
                            input bit eirq, input int ecur, input string tag);
    chk(vvalid == ev, {tag, " valid"}, vvalid, ev);
    if (ev) begin
      chk(int'(vnum) == evec, {tag, " vec"}, vnum, evec);
      chk(int'(vaddr) == eaddr, {tag, " addr"}, vaddr, eaddr);
    end
    chk(irq == eirq, {tag, " irq"}, irq, eirq);
    chk(int'(cur) == ecur, {tag, " cur"}, cur, ecur);
  endtask

  initial begin
    #(200000 * 10);
    chk(0, "watchdog", 0, 1);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    // R1 reset state
    expect_out(0, 0, 0, 0, 0, "R1");
    @(negedge clk); rst_n = 1'b1;
    cyc();
    expect_out(0, 0, 0, 0, 0, "R1 post-release");

    src_en = '1; src_en[9] = 1'b0;
    src_prio[5*3 +: 3] = 3; src_prio[2*3 +: 3] = 3;
    src_prio[20*3 +: 3] = 6; src_prio[9*3 +: 3] = 7;
    // R10 and R3/R5: source 5 -> vector 13 at 0x1E
    src_req[5] = 1; cyc(); src_req[5] = 0; cyc();
    expect_out(1, 13, 'h1E, 1, 0, "R10 R5 src5");
    // R3 tie to lower vector; R2 prio 0 (src 11) and disabled (src 9) never win
    src_req[2] = 1; src_req[11] = 1; src_req[9] = 1; cyc(); src_req = '0; cyc();
    expect_out(1, 10, 'h18, 1, 0, "R3 tie R2");
    // R6 alternate table, no clock edge
    alt_sel = 1; #1;
    chk(int'(vaddr) == 'h118, "R6 alt addr", vaddr, 'h118);
    alt_sel = 0; #1;
    // R8 ack: level 3 taken, src 5 still level 3 so no irq
    ack = 1; cyc(); ack = 0;
    expect_out(1, 13, 'h1E, 0, 3, "R8 ack");
    // R8 ack with irq low ignored
    ack = 1; cyc(); ack = 0;
    expect_out(1, 13, 'h1E, 0, 3, "R8 ignored ack");
    src_req[20] = 1; cyc(); src_req = '0;
    expect_out(1, 28, 'h3C, 1, 3, "R3 higher prio");
    ack = 1; cyc(); ack = 0;
    // R4 traps 3 and 1 together
    trap_req[3] = 1; trap_req[1] = 1; cyc(); trap_req = '0;
    expect_out(1, 1, 'h6, 1, 6, "R4 trap");
    chk(int'(vlvl) == 8, "R4 trap level", vlvl, 8);
    ack = 1; cyc(); ack = 0;
    expect_out(1, 3, 'hA, 0, 8, "R4 nested trap");
    reti = 1; cyc(); reti = 0;
    expect_out(1, 3, 'hA, 1, 6, "R9 pop");
    ack = 1; cyc(); ack = 0;
    reti = 1; cyc(); cyc(); cyc();
    expect_out(1, 13, 'h1E, 1, 0, "R9 unwind");
    cyc(); reti = 0;
    expect_out(1, 13, 'h1E, 1, 0, "R9 empty pop");
    // R10 request while its own clear
    src_req[5] = 1; ack = 1; cyc(); src_req = '0; ack = 0;
    expect_out(1, 13, 'h1E, 0, 3, "R10 set beats clear");
    reti = 1; cyc(); reti = 0;
    // R9 ack and reti together: ack wins
    ack = 1; reti = 1; cyc(); ack = 0; reti = 0;
    expect_out(0, 0, 0, 0, 3, "R9 ack over reti");
    reti = 1; cyc(); reti = 0;

    // random phase checked by model
    for (int k = 0; k < 4000; k++) begin
      src_req  = ($urandom % 4 == 0) ? NS'(1) << ($urandom % NS) : '0;
      trap_req = ($urandom % 40 == 0) ? NT'(1) << ($urandom % NT) : '0;
      ack      = ($urandom % 3 == 0);
      reti     = ($urandom % 4 == 0);
      alt_sel  = ($urandom % 2 == 0);
      if (k % 60 == 0) begin
        for (int n = 0; n < NS; n++) src_prio[3*n +: 3] = 3'($urandom);
        src_en = $urandom;
      end
      cyc();
    end
    ack = 0; reti = 0; src_req = '0; trap_req = '0;
    cyc();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule